// File: doc/BRIEF.md
# Addressed Two-Wire Bus Slave Receiver

This block listens on the clock and data lines of an I2C-style two-wire bus as a receive-only slave. Both lines are brought into the system clock domain through a synchronizer chain. A START condition (data falling while clock is high) arms address recognition. The seven address bits that follow are checked serially. A shifter preloaded with the programmed own address supplies one expected bit per clock, and a counter records how many incoming bits agreed with it. Only a full count marks the slave as addressed.

An addressed slave pulls the data line low through the acknowledge slot. When the ninth clock falls, it releases the data line and holds the clock line low. The host then reads the received byte and frees the clock by writing a zero to the release control. From then on, every byte up to the next START or STOP is taken as data and handled the same way. A slave whose address does not match ignores the clock line until a new START. The open-drain pins appear as separate pull-low enables.

Top module: `tw_slave_rx`

## Requirements
- R1: After reset the block drives neither line low, `rx_flag`, `irq` and `addressed` are 0 and `rx_byte` is 0.
- R2: The block acknowledges an address byte only when all seven address bits, taken most significant first, equal `own_addr`, which is sampled at START. A difference in any single bit, including the last one, gives no acknowledge.
- R3: For an accepted byte, `sda_drive_low` is 1 throughout the high phase of the ninth clock. It returns to 0 at the ninth falling clock edge.
- R4: After an accepted byte, `scl_drive_low` rises at the ninth falling clock edge. A release write with `rel_data` = 1 leaves it set. A write with `rel_data` = 0 clears it on the next cycle.
- R5: `rx_flag` sets on the ninth rising clock edge of an accepted byte. A release write with `rel_data` = 0 clears it.
- R6: `irq` is 1 exactly when `rx_flag` and `irq_en` are both 1.
- R7: After an address mismatch, no later byte is acknowledged or flagged and the clock is never held. This lasts until the next START.
- R8: `rx_byte` shows the last eight bits received, with the first bit in bit 7. For an address byte, bit 0 holds the master's read/write bit.
- R9: After a match, later bytes are acknowledged, flagged and stretched as data without any address check, and `addressed` stays 1.
- R10: A STOP condition (data rising while clock is high) clears `addressed`, and later bytes are ignored until a START. A repeated START restarts address matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| own_addr | input | ADDR_W | Programmed slave address, sampled at START |
| irq_en | input | 1 | Interrupt enable |
| rel_we | input | 1 | Write strobe for the clock-release control |
| rel_data | input | 1 | Value written; 0 releases the clock and clears the flag |
| sda_drive_low | output | 1 | Pull-low enable for the data line (acknowledge) |
| scl_drive_low | output | 1 | Pull-low enable for the clock line (stretch) |
| rx_flag | output | 1 | Byte-received flag |
| irq | output | 1 | Gated interrupt request |
| addressed | output | 1 | Slave is selected and taking data bytes |
| rx_byte | output | DATA_W | Last received byte |

## Verification
The bench builds the block with its default parameters: a seven-bit address, eight-bit bytes and a two-stage synchronizer. Under these settings the bus model can use ten-cycle phases and still sit well above the three-cycle input latency. The full seven-step match count is reached, so mismatches in the first, middle and last address bit can each be shown to block the acknowledge. Open-drain lines are resolved in the bench, so the master sees both the acknowledge and the stretch the way a real bus master would.

// File: rtl/tw_slave_pkg.sv
package tw_slave_pkg;
   typedef enum logic [1:0] {
      MODE_IDLE = 2'd0,
      MODE_ADDR = 2'd1,
      MODE_DATA = 2'd2
   } tw_mode_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
   parameter int STAGES  = 2,
   parameter int W       = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tw_sync needs at least two stages");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL}};
         else        chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/tw_cond_det.sv
module tw_cond_det (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_c,
   output logic stop_c
);
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;
   assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/tw_addr_match.sv
module tw_addr_match #(
   parameter int ADDR_W = 7,
   localparam int CNT_W = $clog2(ADDR_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              bit_en,
   input  logic              bit_val,
   output logic [CNT_W-1:0]  match_cnt,
   output logic              full
);
   logic [ADDR_W-1:0] ref_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_sh    <= '0;
         match_cnt <= '0;
      end else if (load) begin
         ref_sh    <= own_addr;
         match_cnt <= '0;
      end else if (bit_en) begin
         ref_sh <= {ref_sh[ADDR_W-2:0], 1'b0};
         if (ref_sh[ADDR_W-1] == bit_val)
            match_cnt <= match_cnt + 1'b1;
      end
   end

   assign full = (match_cnt == CNT_W'(ADDR_W));
endmodule

// File: rtl/tw_slave_rx.sv
module tw_slave_rx
   import tw_slave_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   localparam int BIT_W      = $clog2(DATA_W + 2),
   localparam int CNT_W      = $clog2(ADDR_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              irq_en,
   input  logic              rel_we,
   input  logic              rel_data,
   output logic              sda_drive_low,
   output logic              scl_drive_low,
   output logic              rx_flag,
   output logic              irq,
   output logic              addressed,
   output logic [DATA_W-1:0] rx_byte
);
   if (ADDR_W + 1 != DATA_W) begin : g_bad_widths
      $error("address plus direction bit must fill one byte");
   end

   logic [1:0]       sync_q;
   logic             scl_s, sda_s;
   logic             scl_rise, scl_fall, start_c, stop_c;
   tw_mode_e         mode;
   logic [BIT_W-1:0] bit_cnt;
   logic [DATA_W-1:0] shreg;
   logic             ack_q, hold_q, flag_q;
   logic             addr_bit_en, full;
   logic [CNT_W-1:0] match_cnt;
   logic             rel_clr, active;

   tw_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(sync_q)
   );
   assign scl_s = sync_q[1];
   assign sda_s = sync_q[0];

   tw_cond_det u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_c(start_c), .stop_c(stop_c)
   );

   assign active      = (mode != MODE_IDLE) && !hold_q;
   assign addr_bit_en = active && (mode == MODE_ADDR) && scl_rise
                        && !start_c && !stop_c
                        && (bit_cnt < BIT_W'(ADDR_W));

   tw_addr_match #(.ADDR_W(ADDR_W)) u_match (
      .clk(clk), .rst_n(rst_n), .load(start_c), .own_addr(own_addr),
      .bit_en(addr_bit_en), .bit_val(sda_s),
      .match_cnt(match_cnt), .full(full)
   );

   assign rel_clr = rel_we && !rel_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode    <= MODE_IDLE;
         bit_cnt <= '0;
         shreg   <= '0;
         ack_q   <= 1'b0;
         hold_q  <= 1'b0;
         flag_q  <= 1'b0;
      end else begin
         if (rel_clr) begin
            hold_q <= 1'b0;
            flag_q <= 1'b0;
         end
         if (start_c) begin
            mode    <= MODE_ADDR;
            bit_cnt <= '0;
            ack_q   <= 1'b0;
         end else if (stop_c) begin
            mode    <= MODE_IDLE;
            bit_cnt <= '0;
            ack_q   <= 1'b0;
         end else if (active) begin
            if (scl_rise) begin
               if (bit_cnt < BIT_W'(DATA_W)) begin
                  shreg   <= {shreg[DATA_W-2:0], sda_s};
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (bit_cnt == BIT_W'(DATA_W)) begin
                  bit_cnt <= bit_cnt + 1'b1;
                  if (mode == MODE_ADDR && !full) begin
                     mode   <= MODE_IDLE;
                     flag_q <= 1'b0;
                  end else begin
                     mode   <= MODE_DATA;
                     flag_q <= 1'b1;
                  end
               end
            end else if (scl_fall) begin
               if (bit_cnt == BIT_W'(DATA_W)) begin
                  if (mode == MODE_DATA || full)
                     ack_q <= 1'b1;
               end else if (bit_cnt == BIT_W'(DATA_W + 1)) begin
                  ack_q   <= 1'b0;
                  hold_q  <= 1'b1;
                  bit_cnt <= '0;
               end
            end
         end
      end
   end

   assign sda_drive_low = ack_q;
   assign scl_drive_low = hold_q;
   assign rx_flag       = flag_q;
   assign irq           = flag_q & irq_en;
   assign addressed     = (mode == MODE_DATA);
   assign rx_byte       = shreg;
endmodule

// File: rtl/tw_slave_rx_chk.sv
module tw_slave_rx_chk #(
   parameter int ADDR_W = 7,
   localparam int CNT_W = $clog2(ADDR_W + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq,
   input logic             irq_en,
   input logic             rx_flag,
   input logic             addressed,
   input logic             sda_drive_low,
   input logic             scl_drive_low,
   input logic             rel_we,
   input logic             rel_data,
   input logic [CNT_W-1:0] match_cnt
);
   p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (irq_en && rx_flag));

   p_hold_persists_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_drive_low && !(rel_we && !rel_data)) |=> scl_drive_low);

   p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_drive_low && rel_we && !rel_data) |=> !scl_drive_low);

   p_flag_addressed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_flag) |-> addressed);

   p_ack_not_stretch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(sda_drive_low && scl_drive_low));

   p_ack_needs_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sda_drive_low |-> (addressed || match_cnt == CNT_W'(ADDR_W)));

   p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      match_cnt <= CNT_W'(ADDR_W));
endmodule

bind tw_slave_rx tw_slave_rx_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq(irq), .irq_en(irq_en),
   .rx_flag(rx_flag), .addressed(addressed),
   .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low),
   .rel_we(rel_we), .rel_data(rel_data), .match_cnt(match_cnt)
);

// File: tb/tw_slave_rx_bench.sv
module tw_slave_rx_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic [6:0] own_addr = 7'h00;
   logic irq_en = 1'b0, rel_we = 1'b0, rel_data = 1'b1;
   logic sda_drive_low, scl_drive_low, rx_flag, irq, addressed;
   logic [7:0] rx_byte;
   wire scl_line = scl_m & ~scl_drive_low;
   wire sda_line = sda_m & ~sda_drive_low;
   int checks = 0, fails = 0;

   always #2 clk = ~clk;

   tw_slave_rx u_tw_slave_rx (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
      .own_addr(own_addr), .irq_en(irq_en), .rel_we(rel_we), .rel_data(rel_data),
      .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low),
      .rx_flag(rx_flag), .irq(irq), .addressed(addressed), .rx_byte(rx_byte)
   );

   // own[15:9] addr[8:2] rw[1] irq_en[0]
   localparam logic [15:0] VEC [7] = '{
      {7'h55, 7'h55, 1'b0, 1'b1},
      {7'h55, 7'h54, 1'b0, 1'b1},
      {7'h55, 7'h15, 1'b1, 1'b1},
      {7'h3A, 7'h3A, 1'b1, 1'b0},
      {7'h7F, 7'h7F, 1'b0, 1'b1},
      {7'h00, 7'h08, 1'b0, 1'b1},
      {7'h00, 7'h00, 1'b1, 1'b1}
   };

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic raise_scl();
      scl_m = 1'b1;
      tick(1);
      while (!scl_line) tick(1);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(5); raise_scl(); tick(10);
      sda_m = 1'b0; tick(10);
      scl_m = 1'b0; tick(10);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(5); raise_scl(); tick(10);
      sda_m = 1'b1; tick(10);
   endtask

   // sends eight bits, then the acknowledge slot; reports ack and flag seen in the slot
   task automatic send_byte(input logic [7:0] b, output bit ack, output bit ack_hi_ok,
                            output bit flag_in_slot);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; tick(5); raise_scl(); tick(10);
         scl_m = 1'b0; tick(5);
      end
      sda_m = 1'b1; tick(5); raise_scl(); tick(2);
      ack_hi_ok = !sda_line;
      tick(5);
      ack = !sda_line;
      ack_hi_ok = ack_hi_ok && ack;
      flag_in_slot = rx_flag;
      tick(3);
      scl_m = 1'b0; tick(10);
   endtask

   task automatic release_clk(bit val);
      rel_we = 1'b1; rel_data = val; tick(1);
      rel_we = 1'b0; rel_data = 1'b1; tick(1);
   endtask

   task automatic run_all();
      bit ack, ackh, fl;
      tick(3);
      // R1: reset state
      chk(!sda_drive_low && !scl_drive_low, "R1", "drive enables", {sda_drive_low, scl_drive_low}, 0);
      chk(!rx_flag && !irq && !addressed, "R1", "flags", {rx_flag, irq, addressed}, 0);
      chk(rx_byte == 8'h00, "R1", "rx_byte", rx_byte, 0);
      rst_n = 1'b1; tick(5);

      foreach (VEC[k]) begin
         logic [6:0] own, adr;
         bit rw, ien, match;
         {own, adr, rw, ien} = VEC[k];
         match = (own == adr);
         own_addr = own; irq_en = ien;
         bus_start();
         send_byte({adr, rw}, ack, ackh, fl);
         chk(ack == match, "R2", $sformatf("ack vec%0d", k), ack, match);
         chk(rx_byte == {adr, rw}, "R8", "address byte", rx_byte, {adr, rw});
         chk(rx_flag == match, "R5", "flag after address", rx_flag, match);
         chk(irq == (match && ien), "R6", "irq", irq, match && ien);
         chk(scl_drive_low == match, "R4", "stretch", scl_drive_low, match);
         chk(sda_drive_low == 1'b0, "R3", "ack released", sda_drive_low, 0);
         if (match) begin
            chk(ackh, "R3", "ack across high phase", ackh, 1);
            chk(addressed, "R9", "addressed", addressed, 1);
            release_clk(1'b0);
            chk(!rx_flag && !scl_drive_low, "R5", "release clears", {rx_flag, scl_drive_low}, 0);
            send_byte(8'hA0 ^ 8'(k), ack, ackh, fl);
            chk(ack && fl, "R9", "data ack+flag", {ack, fl}, 3);
            chk(rx_byte == (8'hA0 ^ 8'(k)), "R8", "data byte", rx_byte, 8'hA0 ^ 8'(k));
            release_clk(1'b0);
         end else begin
            send_byte(8'hFF, ack, ackh, fl);
            chk(!ack && !rx_flag && !scl_drive_low, "R7", "ignored after mismatch",
                {ack, rx_flag, scl_drive_low}, 0);
         end
         bus_stop();
         chk(!addressed, "R10", "stop clears addressed", addressed, 0);
      end

      // R4: write of 1 keeps the clock held
      own_addr = 7'h21; irq_en = 1'b1;
      bus_start();
      send_byte({7'h21, 1'b0}, ack, ackh, fl);
      chk(fl == 1'b1, "R5", "flag during ninth clock", fl, 1);
      release_clk(1'b1); tick(20);
      chk(scl_drive_low && rx_flag, "R4", "write 1 no effect", {scl_drive_low, rx_flag}, 3);
      release_clk(1'b0);
      chk(!scl_drive_low, "R4", "write 0 releases", scl_drive_low, 0);
      // R10: repeated START with a foreign address drops selection
      bus_start();
      send_byte({7'h22, 1'b0}, ack, ackh, fl);
      chk(!ack && !addressed, "R10", "repeated start rematches", {ack, addressed}, 0);
      bus_stop();
      // R10: byte after STOP without START is ignored
      sda_m = 1'b1; scl_m = 1'b0; tick(10);
      send_byte(8'h42, ack, ackh, fl);
      chk(!ack && !rx_flag, "R10", "no start no capture", {ack, rx_flag}, 0);
      scl_m = 1'b1; tick(10);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            fails++; checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
         end
      join_any
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule